// File: doc/BRIEF.md
# Two-slot ROM patch fetch redirector

This block lets a processor correct code that lives in mask ROM. Software loads up to two 16-bit instruction addresses into byte-wide registers and sets a per-slot enable bit. The block then watches every opcode fetch. When the fetch address equals an enabled slot's address, the block raises a redirect flag and presents that slot's fixed RAM vector. The fetch logic then takes its next instruction from RAM, where the patch routine lives. The patch routine returns to ROM by its own jump, which is outside this block.

Registers are reached over a plain byte bus with separate read and write strobes. Slot addresses are split into a high byte and a low byte. The enable register holds one bit per slot, and its unused upper bits always read zero. Redirection is combinational from the fetch inputs and the stored registers. A register write therefore steers comparisons from the clock cycle after the edge that stores it. Neither interface carries a data stream, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented.

Top module: `rpatch_unit`

## Requirements
- R1: After reset, all four address bytes and the enable register read 0x00, and no fetch is redirected.
- R2: Slot 1's address is held as a high byte at 0x020A and a low byte at 0x020B. Slot 2's address is held as a high byte at 0x020C and a low byte at 0x020D. Each byte reads back its last written value.
- R3: The enable register is at 0x020E. Bit 0 enables slot 1 and bit 1 enables slot 2, where 1 means enabled. Bits 7:2 ignore writes and always read 0.
- R4: When the fetch strobe is high and the fetch address equals an enabled slot's address, redirect goes high in the same cycle. The vector output is then 0x0300 for slot 1 and 0x0320 for slot 2. The one-hot slot output marks the slot that won (bit 0 for slot 1, bit 1 for slot 2).
- R5: No redirect occurs while the fetch strobe is low, which covers operand and data accesses. No redirect occurs for a slot whose enable bit is 0, or for any address that differs from the stored slot address.
- R6: If both enabled slots match the same fetch, slot 1 wins and the vector is 0x0300.
- R7: Accesses outside 0x020A–0x020E are not claimed: the hit output stays low, reads return 0x00, and writes change nothing. Any read or write strobe inside the range raises the hit output.
- R8: A register write is seen by comparisons starting in the cycle after the clock edge that stores it. It is not seen in the cycle in which the write is presented.
- R9: While redirect is low, the vector output is 0x0000 and the slot output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 16 | Register bus byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0 when the access is not claimed |
| bus_hit_o | output | 1 | Access falls within the block's register range |
| fetch_i | input | 1 | High during an opcode fetch |
| fetch_addr_i | input | 16 | Opcode fetch address |
| redir_o | output | 1 | Fetch must be taken from the patch vector |
| redir_vec_o | output | 16 | RAM vector of the winning slot |
| redir_slot_o | output | 2 | One-hot winning slot |

## Verification
The assertions assume that strobes and addresses are stable between clock edges. They also assume that read and write strobes are never raised together, and that the read-side properties are judged only while the read strobe is high. The bench drives every input on the falling edge, issues one bus operation at a time, and samples half a cycle later. It sweeps enable codes, fetch addresses near and bit-flipped from each slot, and both strobe levels. This keeps the stimulus within those assumptions.

// File: rtl/rpatch_pkg.sv
package rpatch_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/rpatch_regs.sv
module rpatch_regs
  import rpatch_pkg::*;
#(
  parameter int    NUM_SLOTS = 2,
  parameter addr_t REG_BASE  = 16'h020A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  addr_t                      addr_i,
  input  byte_t                      wdata_i,
  output byte_t                      rdata_o,
  output logic                       hit_o,
  output addr_t [NUM_SLOTS-1:0]      slot_addr_o,
  output logic  [NUM_SLOTS-1:0]      slot_en_o
);
  localparam int    NREG    = 2 * NUM_SLOTS + 1;
  localparam addr_t EN_OFS  = addr_t'(2 * NUM_SLOTS);

  addr_t ofs;
  logic  in_range;
  logic  wr_ok;

  assign ofs      = addr_i - REG_BASE;
  assign in_range = (addr_i >= REG_BASE) && (ofs < addr_t'(NREG));
  assign wr_ok    = wr_i && in_range;
  assign hit_o    = (wr_i || rd_i) && in_range;

  byte_t [NUM_SLOTS-1:0] hi_q;
  byte_t [NUM_SLOTS-1:0] lo_q;
  logic  [NUM_SLOTS-1:0] en_q;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[k] <= '0;
        lo_q[k] <= '0;
      end else if (wr_ok) begin
        if (ofs == addr_t'(2 * k))     hi_q[k] <= wdata_i;
        if (ofs == addr_t'(2 * k + 1)) lo_q[k] <= wdata_i;
      end
    end
    assign slot_addr_o[k] = {hi_q[k], lo_q[k]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        en_q <= '0;
    else if (wr_ok && ofs == EN_OFS)   en_q <= wdata_i[NUM_SLOTS-1:0];
  end
  assign slot_en_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i && in_range) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (ofs == addr_t'(2 * k))     rdata_o = hi_q[k];
        if (ofs == addr_t'(2 * k + 1)) rdata_o = lo_q[k];
      end
      if (ofs == EN_OFS) rdata_o[NUM_SLOTS-1:0] = en_q;
    end
  end
endmodule

// File: rtl/rpatch_cmp.sv
module rpatch_cmp
  import rpatch_pkg::*;
(
  input  logic  fetch_i,
  input  addr_t fetch_addr_i,
  input  addr_t slot_addr_i,
  input  logic  slot_en_i,
  output logic  match_o
);
  assign match_o = fetch_i && slot_en_i && (fetch_addr_i == slot_addr_i);
endmodule

// File: rtl/rpatch_sel.sv
module rpatch_sel
  import rpatch_pkg::*;
#(
  parameter int    NUM_SLOTS  = 2,
  parameter addr_t VEC_BASE   = 16'h0300,
  parameter addr_t VEC_STRIDE = 16'h0020
) (
  input  logic [NUM_SLOTS-1:0] match_i,
  output logic                 redir_o,
  output addr_t                vec_o,
  output logic [NUM_SLOTS-1:0] grant_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (match_i[k]) begin
        grant_o    = '0;
        grant_o[k] = 1'b1;
        vec_o      = VEC_BASE + addr_t'(k) * VEC_STRIDE;
      end
    end
    redir_o = |match_i;
  end
endmodule

// File: rtl/rpatch_unit.sv
module rpatch_unit
  import rpatch_pkg::*;
#(
  parameter int    NUM_SLOTS  = 2,
  parameter addr_t REG_BASE   = 16'h020A,
  parameter addr_t VEC_BASE   = 16'h0300,
  parameter addr_t VEC_STRIDE = 16'h0020
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [15:0]          bus_addr_i,
  input  logic [7:0]           bus_wdata_i,
  output logic [7:0]           bus_rdata_o,
  output logic                 bus_hit_o,
  input  logic                 fetch_i,
  input  logic [15:0]          fetch_addr_i,
  output logic                 redir_o,
  output logic [15:0]          redir_vec_o,
  output logic [NUM_SLOTS-1:0] redir_slot_o
);
  addr_t [NUM_SLOTS-1:0] slot_addr;
  logic  [NUM_SLOTS-1:0] slot_en;
  logic  [NUM_SLOTS-1:0] slot_match;

  rpatch_regs #(.NUM_SLOTS(NUM_SLOTS), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .hit_o(bus_hit_o), .slot_addr_o(slot_addr), .slot_en_o(slot_en)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cmp
    rpatch_cmp u_cmp (
      .fetch_i(fetch_i), .fetch_addr_i(fetch_addr_i),
      .slot_addr_i(slot_addr[k]), .slot_en_i(slot_en[k]),
      .match_o(slot_match[k])
    );
  end

  rpatch_sel #(.NUM_SLOTS(NUM_SLOTS), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_sel (
    .match_i(slot_match), .redir_o(redir_o), .vec_o(redir_vec_o), .grant_o(redir_slot_o)
  );
endmodule

// File: rtl/rpatch_unit_chk.sv
module rpatch_unit_chk #(
  parameter int          NUM_SLOTS  = 2,
  parameter logic [15:0] REG_BASE   = 16'h020A,
  parameter logic [15:0] VEC_BASE   = 16'h0300,
  parameter logic [15:0] VEC_STRIDE = 16'h0020
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_rd_i,
  input logic [15:0]          bus_addr_i,
  input logic [7:0]           bus_rdata_o,
  input logic                 bus_hit_o,
  input logic                 fetch_i,
  input logic                 redir_o,
  input logic [15:0]          redir_vec_o,
  input logic [NUM_SLOTS-1:0] redir_slot_o,
  input logic [NUM_SLOTS-1:0] slot_match
);
  localparam logic [15:0] EN_ADDR = REG_BASE + 16'(2 * NUM_SLOTS);

  // R5: no strobe, no redirect
  assert_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_i |-> !redir_o);

  // R4: a winning slot is one-hot and matches the redirect flag
  assert_slot_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    redir_o |-> $countones(redir_slot_o) == 1);

  // R6: slot 1 wins whenever its comparator fires
  assert_slot1_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_match[0] |-> (redir_vec_o == VEC_BASE && redir_slot_o[0]));

  // R9: quiet outputs while idle
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_o |-> (redir_vec_o == 16'h0000 && redir_slot_o == '0));

  // R7: unclaimed reads return zero
  assert_unclaimed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_hit_o) |-> bus_rdata_o == 8'h00);

  // R3: unused enable bits read zero
  assert_en_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == EN_ADDR) |-> (bus_rdata_o >> NUM_SLOTS) == 8'h00);
endmodule

bind rpatch_unit rpatch_unit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .REG_BASE(REG_BASE), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
  .bus_rdata_o(bus_rdata_o), .bus_hit_o(bus_hit_o), .fetch_i(fetch_i),
  .redir_o(redir_o), .redir_vec_o(redir_vec_o), .redir_slot_o(redir_slot_o),
  .slot_match(slot_match)
);

// File: tb/rpatch_unit_test.sv
`timescale 1ns/1ps
module rpatch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        bus_hit_o;
  logic        fetch_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        redir_o;
  logic [15:0] redir_vec_o;
  logic [1:0]  redir_slot_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rpatch_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_hit_o(bus_hit_o), .fetch_i(fetch_i), .fetch_addr_i(fetch_addr_i),
    .redir_o(redir_o), .redir_vec_o(redir_vec_o), .redir_slot_o(redir_slot_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input bit exp_hit, input string req);
    @(negedge clk);
    bus_rd_i = 1; bus_addr_i = a;
    #1;
    check(bus_rdata_o == exp, req, {24'h0, bus_rdata_o}, {24'h0, exp});
    check(bus_hit_o == exp_hit, req, {31'h0, bus_hit_o}, {31'h0, exp_hit});
    @(negedge clk);
    bus_rd_i = 0;
  endtask

  // expected redirect: slot 1 before slot 2
  task automatic fetch_chk(input logic f, input logic [15:0] fa, input logic [15:0] s1,
                           input logic [15:0] s2, input logic [1:0] en, input string req);
    logic m1, m2;
    logic [15:0] ev;
    logic [1:0]  es;
    m1 = f && en[0] && fa == s1;
    m2 = f && en[1] && fa == s2;
    ev = m1 ? 16'h0300 : (m2 ? 16'h0320 : 16'h0000);
    es = m1 ? 2'b01 : (m2 ? 2'b10 : 2'b00);
    @(negedge clk);
    fetch_i = f; fetch_addr_i = fa;
    #1;
    check(redir_o == (m1 || m2) && redir_vec_o == ev && redir_slot_o == es, req,
          {13'h0, redir_o, redir_slot_o, redir_vec_o}, {13'h0, m1 || m2, es, ev});
  endtask

  task automatic sweep(input logic [15:0] s1, input logic [15:0] s2, input string req);
    wr(16'h020A, s1[15:8]); wr(16'h020B, s1[7:0]);
    wr(16'h020C, s2[15:8]); wr(16'h020D, s2[7:0]);
    for (int e = 0; e < 4; e++) begin
      wr(16'h020E, 8'(e));
      for (int f = 0; f < 2; f++) begin
        for (int d = -2; d <= 3; d++) fetch_chk(f[0], s1 + 16'(d), s1, s2, e[1:0], req);
        for (int b = 0; b < 16; b++) begin
          fetch_chk(f[0], s1 ^ (16'h1 << b), s1, s2, e[1:0], req);
          fetch_chk(f[0], s2 ^ (16'h1 << b), s1, s2, e[1:0], req);
        end
        fetch_chk(f[0], 16'h0000, s1, s2, e[1:0], req);
        fetch_chk(f[0], 16'hFFFF, s1, s2, e[1:0], req);
      end
    end
    fetch_i = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 16'h020A; a <= 16'h020E; a++) rd_chk(16'(a), 8'h00, 1'b1, "R1");
    fetch_chk(1'b1, 16'h0000, 16'h0000, 16'h0000, 2'b00, "R1");
    // R2 readback of every address byte
    for (int p = 0; p < 4; p++) begin
      for (int a = 16'h020A; a <= 16'h020D; a++) begin
        logic [7:0] v;
        v = 8'(8'h3C * (p + 1) + a);
        wr(16'(a), v);
        rd_chk(16'(a), v, 1'b1, "R2");
      end
    end
    // R3 enable register: all 256 write values
    for (int v = 0; v < 256; v++) begin
      wr(16'h020E, 8'(v));
      rd_chk(16'h020E, 8'(v & 3), 1'b1, "R3");
    end
    // R7 out-of-range reads and writes
    wr(16'h020E, 8'h00);
    for (int a = 16'h0200; a <= 16'h0214; a++) begin
      if (a < 16'h020A || a > 16'h020E) begin
        wr(16'(a), 8'hFF);
        rd_chk(16'(a), 8'h00, 1'b0, "R7");
      end
    end
    for (int a = 16'h020A; a <= 16'h020E; a++) rd_chk(16'(a), (a == 16'h020E) ? 8'h00 : 8'(8'h3C * 4 + a), 1'b1, "R7");
    @(negedge clk); bus_wr_i = 1; bus_addr_i = 16'h020C; bus_wdata_i = 8'h00;
    #1 check(bus_hit_o == 1'b1, "R7", {31'h0, bus_hit_o}, 32'h1);
    @(negedge clk); bus_wr_i = 0;
    // R4 R5 distinct slots; R6 equal slots
    sweep(16'h1234, 16'h1235, "R4_R5");
    sweep(16'hA55A, 16'h0F0F, "R4_R5");
    sweep(16'h4000, 16'h4000, "R6");
    // R8 write seen only after its edge
    wr(16'h020E, 8'h00);
    @(negedge clk);
    fetch_i = 1; fetch_addr_i = 16'h4000;
    bus_wr_i = 1; bus_addr_i = 16'h020E; bus_wdata_i = 8'h02;
    #1 check(redir_o == 1'b0, "R8", {31'h0, redir_o}, 32'h0);
    @(negedge clk); bus_wr_i = 0;
    #1 check(redir_o && redir_vec_o == 16'h0320, "R8", {15'h0, redir_o, redir_vec_o}, {15'h0, 1'b1, 16'h0320});
    // R9 idle outputs with strobe low
    @(negedge clk); fetch_i = 0;
    #1 check(!redir_o && redir_vec_o == 16'h0 && redir_slot_o == 2'b00, "R9",
             {13'h0, redir_o, redir_slot_o, redir_vec_o}, 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule